// File: doc/BRIEF.md
# TDM Per-Channel Output Connection Selector

This block decides what each output timeslot of a time-division switch carries. Every output timeslot has its own 12-bit connection word. A processor write port places the word at an address built from the output stream and channel. Bit 0 of the word is a mode flag.

- When the flag is clear, the word points at a source byte, given as a source stream and a source channel. The block fetches that byte from an external data memory.
- When the flag is set, a 2-bit control field picks one of four actions:
  - fetch the byte that sits at the same stream and channel on the input side;
  - send an 8-bit message carried inside the word;
  - release the output for the whole slot;
  - forward a byte from an external test-pattern source.

A timeslot strobe marks the start of each slot and carries the slot's index. On each strobe the block looks up the word for the following slot. It then fetches the data byte and prepares the result. At the next strobe that result becomes the registered output byte and enable. Slot indices count stream-major, with the channel in the low bits. The last index of a frame is followed by index 0.

Top module: `tdmcs_selector`

## Requirements
- R1: While reset is held and after it, `out_byte` is 0 and `out_en` is 0. The first slot after reset also shows 0/0, because no lookup has been made for it.
- R2: A word with bit 0 = 0 makes the slot carry the data-memory byte at address {word[11:8], word[7:1]}, with `out_en` = 1. Bits 11:8 are the source stream and bits 7:1 the source channel.
- R3: Connection-memory location `stream*N_CHAN + channel` holds the word for that output slot. A write with `cpu_we` = 1 stores `cpu_wdata` there. `cpu_rdata` shows the word at `cpu_addr` one clock after the address is applied.
- R4: A word with bit 0 = 1 and bits 2:1 = 01 makes the slot carry word[10:3] unchanged, with `out_en` = 1.
- R5: A word with bit 0 = 1 and bits 2:1 = 10 keeps `out_en` at 0 and `out_byte` at 0 for the whole slot.
- R6: A word with bit 0 = 1 and bits 2:1 = 11 makes the slot carry the `pat_byte` present on the clock edge that starts the slot, with `out_en` = 1.
- R7: A word with bit 0 = 1 and bits 2:1 = 00 makes the slot carry the data-memory byte at {output stream, output channel}. Both fields are zero-extended to 4 and 7 bits.
- R8: `out_byte` and `out_en` change only on the clock edge where `ts_adv` = 1. They hold for the rest of the slot, and a slot lasts at least 3 clocks.
- R9: The word for slot N+1 is read on the edge that starts slot N. A later write to that location does not change slot N+1 in the current frame. It takes effect the next time that location is read.
- R10: After the slot with the last index comes slot 0. The word for slot 0 is read on the edge that starts the last slot.
- R11: `dm_re` is 1 for exactly the one clock after each slot-start edge whose lookup word is in the R2 or R7 mode. It is 0 otherwise. Data-memory read data is taken one clock after `dm_re`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_adv | input | 1 | Marks the first clock of a timeslot |
| ts_cur | input | 9 | Index of the slot that starts on this strobe |
| cpu_we | input | 1 | Connection-memory write strobe |
| cpu_addr | input | 9 | Connection-memory address for write and read |
| cpu_wdata | input | 12 | Connection word to write |
| cpu_rdata | output | 12 | Connection word read back, one clock late |
| dm_re | output | 1 | Data-memory read strobe |
| dm_raddr | output | 11 | Data-memory address {stream[3:0], channel[6:0]} |
| dm_rdata | input | 8 | Data-memory byte, valid one clock after dm_re |
| pat_byte | input | 8 | Byte from the test-pattern source |
| out_byte | output | 8 | Output byte of the current slot |
| out_en | output | 1 | Output drive enable of the current slot |

## Verification
The bench goes after the look-ahead. A design that used the current slot's word would show every byte one slot late, so almost every slot check would fail. A write to the next slot's location made just after its lookup must still leave the old content visible for that slot. A design that bypassed the write would show the new byte a frame early.

The wrap from the last slot to slot 0 is covered by running three whole frames. Dropping the wrap would leave slot 0 carrying stale data. The bench also keeps message and pass-through words apart from connection words. A decoder that read bits 2:1 while bit 0 was clear would release the output or send the wrong byte. Finally, it counts data-memory reads per slot. A design that fetched on message, release or test slots would show a stray strobe.

// File: rtl/tdmcs_pkg.sv
package tdmcs_pkg;
  localparam int CW_W     = 12;
  localparam int SRC_ST_W = 4;
  localparam int SRC_CH_W = 7;
  localparam int DM_AW    = SRC_ST_W + SRC_CH_W;
  localparam int BYTE_W   = 8;

  typedef enum logic [2:0] {
    CM_CONN,
    CM_PASS,
    CM_MSG,
    CM_HIZ,
    CM_TEST
  } cmode_e;

  typedef struct packed {
    logic              en;
    logic              use_pat;
    logic [BYTE_W-1:0] dat;
  } stage_t;

  function automatic cmode_e word_mode(input logic [CW_W-1:0] w);
    cmode_e m;
    if (!w[0]) m = CM_CONN;
    else begin
      case (w[2:1])
        2'b00:   m = CM_PASS;
        2'b01:   m = CM_MSG;
        2'b10:   m = CM_HIZ;
        default: m = CM_TEST;
      endcase
    end
    return m;
  endfunction

  function automatic logic [DM_AW-1:0] word_src(input logic [CW_W-1:0] w);
    return {w[11:8], w[7:1]};
  endfunction

  function automatic logic [BYTE_W-1:0] word_msg(input logic [CW_W-1:0] w);
    return w[10:3];
  endfunction

  function automatic logic needs_data(input cmode_e m);
    return (m == CM_CONN) || (m == CM_PASS);
  endfunction
endpackage

// File: rtl/tdmcs_cmem.sv
module tdmcs_cmem
  import tdmcs_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [CW_W-1:0] wdata,
  output logic [CW_W-1:0] cpu_word,
  input  logic            pf_re,
  input  logic [AW-1:0]   pf_addr,
  output logic [CW_W-1:0] pf_word
);
  logic [CW_W-1:0] mem [DEPTH];

  // Both read ports see the content before a write in the same clock.
  always_ff @(posedge clk) begin
    if (we) mem[cpu_addr] <= wdata;
    if (pf_re) pf_word <= mem[pf_addr];
    cpu_word <= mem[cpu_addr];
  end
endmodule

// File: rtl/tdmcs_fetch.sv
module tdmcs_fetch
  import tdmcs_pkg::*;
#(
  parameter int SLOT_W = 9,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pf_go,
  input  logic [SLOT_W-1:0] pf_slot,
  input  logic [CW_W-1:0]   cw,
  output logic              dm_re,
  output logic [DM_AW-1:0]  dm_raddr,
  input  logic [BYTE_W-1:0] dm_rdata,
  output stage_t            staged
);
  logic              v1, v2;
  logic [SLOT_W-1:0] slot1;
  logic [CW_W-1:0]   w2;
  cmode_e            mode1, mode2;

  // Same stream and channel on the input side, both zero-extended.
  function automatic logic [DM_AW-1:0] pass_addr(input logic [SLOT_W-1:0] s);
    logic [SRC_ST_W-1:0] st;
    logic [SRC_CH_W-1:0] ch;
    st = SRC_ST_W'(s >> CH_W);
    ch = SRC_CH_W'(s[CH_W-1:0]);
    return {st, ch};
  endfunction

  function automatic stage_t build(input cmode_e m, input logic [CW_W-1:0] w,
                                   input logic [BYTE_W-1:0] d);
    stage_t r;
    r = '0;
    case (m)
      CM_HIZ:  r = '0;
      CM_MSG:  begin r.en = 1'b1; r.dat = word_msg(w); end
      CM_TEST: begin r.en = 1'b1; r.use_pat = 1'b1; end
      default: begin r.en = 1'b1; r.dat = d; end
    endcase
    return r;
  endfunction

  assign mode1    = word_mode(cw);
  assign dm_re    = v1 && needs_data(mode1);
  assign dm_raddr = (mode1 == CM_CONN) ? word_src(cw) : pass_addr(slot1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1     <= 1'b0;
      v2     <= 1'b0;
      slot1  <= '0;
      w2     <= '0;
      mode2  <= CM_HIZ;
      staged <= '0;
    end else begin
      v1 <= pf_go;
      if (pf_go) slot1 <= pf_slot;
      v2 <= v1;
      if (v1) begin
        w2    <= cw;
        mode2 <= mode1;
      end
      if (v2) staged <= build(mode2, w2, dm_rdata);
    end
  end
endmodule

// File: rtl/tdmcs_outreg.sv
module tdmcs_outreg
  import tdmcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ts_adv,
  input  stage_t            staged,
  input  logic [BYTE_W-1:0] pat_byte,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_byte <= '0;
      out_en   <= 1'b0;
    end else if (ts_adv) begin
      out_en   <= staged.en;
      out_byte <= staged.use_pat ? pat_byte : staged.dat;
    end
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_adv |=> ($stable(out_byte) && $stable(out_en)));

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_adv && !staged.en) |=> (!out_en && out_byte == '0));

  a_r6_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_adv && staged.use_pat) |=> (out_en && out_byte == $past(pat_byte)));
endmodule

// File: rtl/tdmcs_selector.sv
module tdmcs_selector
  import tdmcs_pkg::*;
#(
  parameter int N_STREAM = 16,
  parameter int N_CHAN   = 32,
  localparam int N_SLOT  = N_STREAM * N_CHAN,
  localparam int SLOT_W  = $clog2(N_SLOT),
  localparam int CH_W    = $clog2(N_CHAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ts_adv,
  input  logic [SLOT_W-1:0] ts_cur,
  input  logic              cpu_we,
  input  logic [SLOT_W-1:0] cpu_addr,
  input  logic [CW_W-1:0]   cpu_wdata,
  output logic [CW_W-1:0]   cpu_rdata,
  output logic              dm_re,
  output logic [DM_AW-1:0]  dm_raddr,
  input  logic [BYTE_W-1:0] dm_rdata,
  input  logic [BYTE_W-1:0] pat_byte,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_en
);
  function automatic logic [SLOT_W-1:0] slot_after(input logic [SLOT_W-1:0] s);
    return (s == SLOT_W'(N_SLOT - 1)) ? '0 : SLOT_W'(s + 1'b1);
  endfunction

  logic [SLOT_W-1:0] pf_addr;
  logic [CW_W-1:0]   pf_word;
  stage_t            staged;

  assign pf_addr = slot_after(ts_cur);

  tdmcs_cmem #(.DEPTH(N_SLOT)) u_cmem (
    .clk      (clk),
    .we       (cpu_we),
    .cpu_addr (cpu_addr),
    .wdata    (cpu_wdata),
    .cpu_word (cpu_rdata),
    .pf_re    (ts_adv),
    .pf_addr  (pf_addr),
    .pf_word  (pf_word)
  );

  tdmcs_fetch #(.SLOT_W(SLOT_W), .CH_W(CH_W)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .pf_go    (ts_adv),
    .pf_slot  (pf_addr),
    .cw       (pf_word),
    .dm_re    (dm_re),
    .dm_raddr (dm_raddr),
    .dm_rdata (dm_rdata),
    .staged   (staged)
  );

  tdmcs_outreg u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .ts_adv   (ts_adv),
    .staged   (staged),
    .pat_byte (pat_byte),
    .out_byte (out_byte),
    .out_en   (out_en)
  );

  a_r11_after_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    dm_re |-> $past(ts_adv));

  a_r11_single: assert property (@(posedge clk) disable iff (!rst_n)
    dm_re |=> !dm_re);
endmodule

// File: tb/sim_tdmcs_selector.sv
module sim_tdmcs_selector;
  localparam int NS = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ts_adv = 1'b0;
  logic [8:0]  ts_cur = '0;
  logic        cpu_we = 1'b0;
  logic [8:0]  cpu_addr = '0;
  logic [11:0] cpu_wdata = '0;
  logic [11:0] cpu_rdata;
  logic        dm_re;
  logic [10:0] dm_raddr;
  logic [7:0]  dm_rdata = '0;
  logic [7:0]  pat_byte = '0;
  logic [7:0]  out_byte;
  logic        out_en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [11:0] mir [NS];

  always #5 clk = ~clk;

  tdmcs_selector u0 (
    .clk(clk), .rst_n(rst_n), .ts_adv(ts_adv), .ts_cur(ts_cur),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .dm_re(dm_re), .dm_raddr(dm_raddr),
    .dm_rdata(dm_rdata), .pat_byte(pat_byte), .out_byte(out_byte),
    .out_en(out_en)
  );

  function automatic logic [7:0] dm_val(input logic [10:0] a);
    return 8'((a * 37) + (a >> 5) + 11);
  endfunction

  // Data memory with one clock of read latency.
  always @(posedge clk) dm_rdata <= dm_val(dm_raddr);

  function automatic logic [11:0] rand_word();
    logic [11:0] r;
    r = 12'($urandom);
    case ($urandom % 5)
      0:       r[0] = 1'b0;
      1:       r[2:0] = 3'b001;
      2:       r[2:0] = 3'b011;
      3:       r[2:0] = 3'b101;
      default: r[2:0] = 3'b111;
    endcase
    return r;
  endfunction

  function automatic logic uses_dm(input logic [11:0] w);
    return !w[0] || (w[2:1] == 2'b00);
  endfunction

  function automatic logic [8:0] exp_out(input logic [11:0] w, input logic [8:0] s,
                                         input logic [7:0] pat);
    if (!w[0]) return {1'b1, dm_val({w[11:8], w[7:1]})};
    case (w[2:1])
      2'b00:   return {1'b1, dm_val({s[8:5], 2'b00, s[4:0]})};
      2'b01:   return {1'b1, w[10:3]};
      2'b10:   return 9'h000;
      default: return {1'b1, pat};
    endcase
  endfunction

  function automatic string out_tag(input logic [11:0] w, input logic [8:0] s,
                                    input logic late, input logic valid);
    if (!valid) return "R1";
    if (late) return "R9";
    if (s == 0) return "R10";
    if (!w[0]) return "R2";
    case (w[2:1])
      2'b00:   return "R7";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] cur_word, nxt_word;
    logic        cur_late, nxt_late, cur_valid;
    logic [8:0]  nx, exp9;
    logic [7:0]  hold_b;
    logic        hold_e;
    logic [8:0]  raddr;
    void'($urandom(32'd4242));
    cur_word = '0; cur_late = 1'b0; cur_valid = 1'b0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", {out_en, out_byte}, 9'h000);
    rst_n = 1'b1;

    // Fill every location; a few are placed for directed corners.
    for (int a = 0; a < NS; a++) begin
      logic [11:0] w;
      w = rand_word();
      if (a == 1)   w = {1'b0, 8'hA5, 3'b011};    // message 0xA5
      if (a == 2)   w = 12'h005;                  // release
      if (a == 3)   w = 12'h007;                  // test pattern
      if (a == 4)   w = {4'hF, 7'h7F, 1'b0};      // far source
      if (a == 0)   w = {4'h0, 7'h00, 1'b0};      // source 0
      if (a == 511) w = 12'h001;                  // pass-through at frame end
      cpu_we = 1'b1; cpu_addr = 9'(a); cpu_wdata = w; mir[a] = w;
      @(posedge clk); @(negedge clk);
    end
    cpu_we = 1'b0;
    chk("R1", {out_en, out_byte}, 9'h000);

    for (int f = 0; f < 3; f++) begin
      for (int s = 0; s < NS; s++) begin
        nx = 9'((s + 1) % NS);
        ts_adv = 1'b1; ts_cur = 9'(s); pat_byte = 8'($urandom);
        nxt_word = mir[nx]; nxt_late = 1'b0;
        @(posedge clk); @(negedge clk);
        exp9 = cur_valid ? exp_out(cur_word, 9'(s), pat_byte) : 9'h000;
        chk(out_tag(cur_word, 9'(s), cur_late, cur_valid), {out_en, out_byte}, exp9);
        chk("R11", dm_re, uses_dm(nxt_word));
        ts_adv = 1'b0;
        hold_b = out_byte; hold_e = out_en;
        if ((f == 1 && s == 200) || ($urandom % 6 == 0)) begin
          logic [8:0] wa;
          wa = (f == 1 && s == 200) || ($urandom % 2 == 0) ? nx : 9'($urandom);
          cpu_we = 1'b1; cpu_addr = wa; cpu_wdata = rand_word();
          if (f == 1 && s == 200) cpu_wdata = {1'b0, 8'h3C, 3'b011};
          mir[wa] = cpu_wdata;
          if (wa == nx) nxt_late = 1'b1;
        end
        @(posedge clk); @(negedge clk);
        cpu_we = 1'b0;
        raddr = 9'($urandom); cpu_addr = raddr;
        chk("R11", dm_re, 1'b0);
        @(posedge clk); @(negedge clk);
        chk("R3", cpu_rdata, mir[raddr]);
        @(posedge clk); @(negedge clk);
        chk("R8", {out_en, out_byte}, {hold_e, hold_b});
        cur_word = nxt_word; cur_late = nxt_late; cur_valid = 1'b1;
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule